// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block turns one 32-bit command word into a single I2C master transaction, sequenced at byte granularity. A write of the command word starts the sequence: a START, an address phase in either 7-bit or 10-bit form, and then a data phase of the programmed length. The transaction then either closes with a STOP or leaves the bus held so that the next command begins with a repeated START. The SCL/SDA waveforms, timing and clock stretching belong to a separate bit engine. The sequencer hands that engine one request at a time: START, write byte, read byte or STOP. The engine answers each request with a done pulse. Along with the done pulse it reports an ACK or NACK for written bytes and the received byte for reads. It can also flag arbitration loss or a bus error.

Write data is taken from a byte source with a valid/pop pair, and read data is pushed into a byte sink. A 32-bit status word gives the operation, the transaction state, a coded abort cause and the number of data bytes transferred. Two separate one-cycle pulses tell software which kind of completion happened: one when the transaction ended with a STOP, and the other when the bus was left held for a repeated START.

Top module: `i2c_xact_ctrl`

## Requirements
- R1: Command word fields: bit 0 direction (1 = read), bits 7:1 seven address bits, bits 10:8 extension bits, bit 11 start-byte enable, bits 13:12 address mode (2 = 10-bit, any other value = 7-bit), bit 14 STOP request, bits 25:15 length. In 7-bit mode the address byte is {bits 7:1, direction}.
- R2: In 10-bit mode the first address byte is 11110, then bits 10:9, then 0. The second byte is {bit 8, bits 7:1}. A 10-bit read then issues a repeated START followed by 11110, bits 10:9, 1.
- R3: With start-byte enable set, the sequence opens with START, byte 0x01 (its acknowledge is ignored) and a second START, and only then sends the address.
- R4: The data phase moves exactly length bytes. Writes take bytes from the TX source and pop one byte per completed byte. Reads push each received byte to the RX sink and acknowledge every byte except the last, which is answered with NACK. A length of zero skips the data phase.
- R5: With STOP requested, a STOP request follows the data phase. When that STOP completes, done_o pulses for one cycle and the state becomes OK.
- R6: Without STOP, no STOP is issued. done_nostop_o pulses for one cycle, the state becomes OK and the bus stays held. The next command starts with a START request, which acts as a repeated START.
- R7: Status word layout: bits 1:0 operation (0 write, 1 read), bits 3:2 state (0 none, 1 ongoing, 2 OK, 3 abort), bits 6:4 abort cause, bits 8:7 receive type (always 0), bits 19:9 count of data bytes completed (a NACKed write byte is not counted). All other bits are 0.
- R8: A NACK on any address byte aborts with cause 0. A NACK on a written data byte aborts with cause 1. An abort returns the block to idle at once and issues no further requests.
- R9: Arbitration loss aborts with cause 3. A bus error (an unexpected START or STOP) aborts with cause 7. Both take effect in any active step.
- R10: A length greater than MAX_LEN aborts at once with cause 6 and makes no bus request.
- R11: A command is accepted only when the block is idle or holding for a repeated START. A command written while busy has no effect. State and cause hold until the next accepted command.
- R12: After reset the status word is 0, and no request, pop, push or completion pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | CMD_W | Command word |
| bus_req_o | output | 1 | Request to the bit engine is pending |
| bus_op_o | output | 2 | Request kind: 0 START, 1 write byte, 2 read byte, 3 STOP |
| bus_byte_o | output | 8 | Byte to send for a write request |
| bus_ack_o | output | 1 | For a read request: 1 = ACK the byte, 0 = NACK |
| bus_done_i | input | 1 | Current request finished |
| bus_nack_i | input | 1 | Written byte was NACKed (valid with done) |
| bus_arb_lost_i | input | 1 | Arbitration lost |
| bus_err_i | input | 1 | Unexpected START or STOP on the bus |
| bus_rdata_i | input | 8 | Received byte (valid with done) |
| tx_valid_i | input | 1 | TX source has a byte |
| tx_data_i | input | 8 | TX source byte |
| tx_pop_o | output | 1 | TX byte consumed |
| rx_push_o | output | 1 | RX byte valid |
| rx_data_o | output | 8 | RX byte |
| status_o | output | 32 | Status word |
| done_o | output | 1 | Transaction ended with STOP |
| done_nostop_o | output | 1 | Transaction ended holding the bus |

## Verification
The assertions assume a well-behaved bit engine and TX source. The engine raises done only while a request is pending, and at most once per request. It raises NACK, arbitration loss and bus error only together with done. The TX source presents tx_data_i steadily and does not drop valid while a write byte is requested. The bench's engine model keeps to these rules by construction: it answers each request exactly one cycle after seeing it and injects one fault at a chosen request index. The TX model keeps valid high and changes data only on a pop. Command strobes arrive on falling edges, away from the edges where the model responds.

// File: rtl/i2c_xact_pkg.sv
package i2c_xact_pkg;
  localparam int LEN_W = 11;
  localparam int FIELD_END = 25;

  typedef enum logic [1:0] {BUS_START = 2'd0, BUS_WR = 2'd1, BUS_RD = 2'd2, BUS_STOP = 2'd3} bus_op_e;
  typedef enum logic [1:0] {ST_NOP = 2'd0, ST_BUSY = 2'd1, ST_OK = 2'd2, ST_ABORT = 2'd3} xact_state_e;

  localparam logic [2:0] CAUSE_ADDR_NACK = 3'd0;
  localparam logic [2:0] CAUSE_DATA_NACK = 3'd1;
  localparam logic [2:0] CAUSE_ARB       = 3'd3;
  localparam logic [2:0] CAUSE_OVF       = 3'd6;
  localparam logic [2:0] CAUSE_BERR      = 3'd7;

  typedef struct packed {
    logic             rd;
    logic [6:0]       a7;
    logic [2:0]       ext;
    logic             sb;
    logic             ten;
    logic             stop;
    logic [LEN_W-1:0] len;
  } cmd_t;
endpackage

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
  import i2c_xact_pkg::*;
#(
  parameter int CMD_W = 32
) (
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_t             fld_o,
  output logic [7:0]       adr_first_o,
  output logic [7:0]       adr_lo_o,
  output logic [7:0]       adr_rd_o
);
  assign fld_o.rd   = cmd_i[0];
  assign fld_o.a7   = cmd_i[7:1];
  assign fld_o.ext  = cmd_i[10:8];
  assign fld_o.sb   = cmd_i[11];
  assign fld_o.ten  = (cmd_i[13:12] == 2'd2);
  assign fld_o.stop = cmd_i[14];
  assign fld_o.len  = cmd_i[FIELD_END:FIELD_END-LEN_W+1];

  // 10-bit header always goes out as write first; read header follows restart
  assign adr_first_o = fld_o.ten ? {5'b11110, fld_o.ext[2:1], 1'b0} : {fld_o.a7, fld_o.rd};
  assign adr_lo_o    = {fld_o.ext[0], fld_o.a7};
  assign adr_rd_o    = {5'b11110, fld_o.ext[2:1], 1'b1};

  generate
    if (CMD_W > FIELD_END + 1) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^cmd_i[CMD_W-1:FIELD_END+1];
    end
  endgenerate
endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
  import i2c_xact_pkg::*;
#(
  parameter int MAX_LEN = 2047
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  cmd_t             fld_i,
  input  logic [7:0]       adr_first_i,
  input  logic [7:0]       adr_lo_i,
  input  logic [7:0]       adr_rd_i,
  input  logic             bus_done_i,
  input  logic             bus_nack_i,
  input  logic             bus_arb_lost_i,
  input  logic             bus_err_i,
  input  logic [7:0]       bus_rdata_i,
  input  logic             tx_valid_i,
  input  logic [7:0]       tx_data_i,
  output logic             bus_req_o,
  output bus_op_e          bus_op_o,
  output logic [7:0]       bus_byte_o,
  output logic             bus_ack_o,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  output logic             load_o,
  output logic             start_evt_o,
  output logic             ok_evt_o,
  output logic             abort_evt_o,
  output logic [2:0]       cause_o,
  output logic [LEN_W-1:0] cnt_o,
  output logic             done_o,
  output logic             done_nostop_o
);
  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_START, S_SB, S_SB_RS, S_ADR, S_ADR_LO,
    S_ADR_RS, S_ADR_RD, S_TXD, S_RXD, S_STOP
  } seq_e;

  seq_e st_q, st_d, fin, after_adr;
  cmd_t cmd_q;
  logic [7:0] a_first_q, a_lo_q, a_rd_q;
  logic [LEN_W-1:0] cnt_q;
  logic dn_q, dns_q, dn_d, dns_d;
  logic active, accept, ovf, last_byte, xfer_ok, step;
  logic cnt_inc, ok_d, abort_d;
  logic [2:0] cause_d;

  assign active    = (st_q != S_IDLE) && (st_q != S_HOLD);
  assign accept    = cmd_we_i && !active;
  assign ovf       = int'(fld_i.len) > MAX_LEN;
  assign last_byte = (cnt_q + LEN_W'(1)) == cmd_q.len;
  assign fin       = cmd_q.stop ? S_STOP : S_HOLD;
  assign after_adr = (cmd_q.len == '0) ? fin : (cmd_q.rd ? S_RXD : S_TXD);

  assign bus_req_o = active && !(st_q == S_TXD && !tx_valid_i);
  assign step      = bus_req_o && bus_done_i;
  assign xfer_ok   = step && !bus_err_i && !bus_arb_lost_i;
  assign tx_pop_o  = xfer_ok && (st_q == S_TXD);
  assign rx_push_o = xfer_ok && (st_q == S_RXD);
  assign rx_data_o = bus_rdata_i;
  assign bus_ack_o = (st_q == S_RXD) && !last_byte;

  always_comb begin
    unique case (st_q)
      S_START, S_SB_RS, S_ADR_RS: bus_op_o = BUS_START;
      S_STOP:                     bus_op_o = BUS_STOP;
      S_RXD:                      bus_op_o = BUS_RD;
      default:                    bus_op_o = BUS_WR;
    endcase
    unique case (st_q)
      S_SB:     bus_byte_o = 8'h01;
      S_ADR:    bus_byte_o = a_first_q;
      S_ADR_LO: bus_byte_o = a_lo_q;
      S_ADR_RD: bus_byte_o = a_rd_q;
      S_TXD:    bus_byte_o = tx_data_i;
      default:  bus_byte_o = 8'h00;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    cnt_inc = 1'b0;
    ok_d    = 1'b0;
    dn_d    = 1'b0;
    dns_d   = 1'b0;
    abort_d = 1'b0;
    cause_d = CAUSE_ADDR_NACK;
    if (accept) begin
      if (ovf) begin
        abort_d = 1'b1;
        cause_d = CAUSE_OVF;
        st_d    = S_IDLE;
      end else begin
        st_d = S_START;
      end
    end else if (active && bus_err_i) begin
      abort_d = 1'b1;
      cause_d = CAUSE_BERR;
    end else if (active && bus_arb_lost_i) begin
      abort_d = 1'b1;
      cause_d = CAUSE_ARB;
    end else if (step) begin
      unique case (st_q)
        S_START:  st_d = cmd_q.sb ? S_SB : S_ADR;
        S_SB:     st_d = S_SB_RS;
        S_SB_RS:  st_d = S_ADR;
        S_ADR:    if (bus_nack_i) abort_d = 1'b1;
                  else st_d = cmd_q.ten ? S_ADR_LO : after_adr;
        S_ADR_LO: if (bus_nack_i) abort_d = 1'b1;
                  else st_d = cmd_q.rd ? S_ADR_RS : after_adr;
        S_ADR_RS: st_d = S_ADR_RD;
        S_ADR_RD: if (bus_nack_i) abort_d = 1'b1;
                  else st_d = after_adr;
        S_TXD: begin
          if (bus_nack_i) begin
            abort_d = 1'b1;
            cause_d = CAUSE_DATA_NACK;
          end else begin
            cnt_inc = 1'b1;
            if (last_byte) st_d = fin;
          end
        end
        S_RXD: begin
          cnt_inc = 1'b1;
          if (last_byte) st_d = fin;
        end
        S_STOP: begin
          st_d = S_IDLE;
          ok_d = 1'b1;
          dn_d = 1'b1;
        end
        default: st_d = S_IDLE;
      endcase
    end
    if (abort_d) st_d = S_IDLE;
    if (st_d == S_HOLD && st_q != S_HOLD) begin
      ok_d  = 1'b1;
      dns_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      cmd_q     <= '0;
      a_first_q <= '0;
      a_lo_q    <= '0;
      a_rd_q    <= '0;
      cnt_q     <= '0;
      dn_q      <= 1'b0;
      dns_q     <= 1'b0;
    end else begin
      st_q  <= st_d;
      dn_q  <= dn_d;
      dns_q <= dns_d;
      if (accept) begin
        cmd_q     <= fld_i;
        a_first_q <= adr_first_i;
        a_lo_q    <= adr_lo_i;
        a_rd_q    <= adr_rd_i;
        cnt_q     <= '0;
      end else if (cnt_inc) begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

  assign load_o        = accept;
  assign start_evt_o   = accept && !ovf;
  assign ok_evt_o      = ok_d;
  assign abort_evt_o   = abort_d;
  assign cause_o       = cause_d;
  assign cnt_o         = cnt_q;
  assign done_o        = dn_q;
  assign done_nostop_o = dns_q;

  // R5
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && done_nostop_o));
  // R4
  rx_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> (bus_done_i && bus_op_o == BUS_RD));
  // R4
  tx_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> tx_valid_i);
  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cmd_q.len);
  // R10
  ovf_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && ovf) |=> !bus_req_o);
endmodule

// File: rtl/i2c_xact_status.sv
module i2c_xact_status
  import i2c_xact_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             rd_i,
  input  logic             start_evt_i,
  input  logic             ok_evt_i,
  input  logic             abort_evt_i,
  input  logic [2:0]       cause_i,
  input  logic [LEN_W-1:0] cnt_i,
  output logic [31:0]      status_o
);
  xact_state_e state_q;
  logic [2:0]  cause_q;
  logic        rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NOP;
      cause_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      if (load_i) rd_q <= rd_i;
      if (abort_evt_i) begin
        state_q <= ST_ABORT;
        cause_q <= cause_i;
      end else if (start_evt_i) begin
        state_q <= ST_BUSY;
        cause_q <= '0;
      end else if (ok_evt_i) begin
        state_q <= ST_OK;
      end
    end
  end

  // receive type field is always zero: master only
  assign status_o = {{(32-LEN_W-9){1'b0}}, cnt_i, 2'b00, cause_q, state_q, 1'b0, rd_q};

  // R8
  abort_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_evt_i |=> (state_q == ST_ABORT && cause_q == $past(cause_i)));
  // R5
  ok_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_evt_i && !abort_evt_i && !start_evt_i) |=> state_q == ST_OK);
endmodule

// File: rtl/i2c_xact_ctrl.sv
module i2c_xact_ctrl
  import i2c_xact_pkg::*;
#(
  parameter int CMD_W   = 32,
  parameter int MAX_LEN = 2047
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             bus_req_o,
  output logic [1:0]       bus_op_o,
  output logic [7:0]       bus_byte_o,
  output logic             bus_ack_o,
  input  logic             bus_done_i,
  input  logic             bus_nack_i,
  input  logic             bus_arb_lost_i,
  input  logic             bus_err_i,
  input  logic [7:0]       bus_rdata_i,
  input  logic             tx_valid_i,
  input  logic [7:0]       tx_data_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  output logic [31:0]      status_o,
  output logic             done_o,
  output logic             done_nostop_o
);
  cmd_t             fld;
  logic [7:0]       adr_first, adr_lo, adr_rd;
  bus_op_e          bus_op;
  logic             load, start_evt, ok_evt, abort_evt;
  logic [2:0]       cause;
  logic [LEN_W-1:0] cnt;

  i2c_cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .cmd_i       (cmd_i),
    .fld_o       (fld),
    .adr_first_o (adr_first),
    .adr_lo_o    (adr_lo),
    .adr_rd_o    (adr_rd)
  );

  i2c_xact_seq #(.MAX_LEN(MAX_LEN)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_we_i       (cmd_we_i),
    .fld_i          (fld),
    .adr_first_i    (adr_first),
    .adr_lo_i       (adr_lo),
    .adr_rd_i       (adr_rd),
    .bus_done_i     (bus_done_i),
    .bus_nack_i     (bus_nack_i),
    .bus_arb_lost_i (bus_arb_lost_i),
    .bus_err_i      (bus_err_i),
    .bus_rdata_i    (bus_rdata_i),
    .tx_valid_i     (tx_valid_i),
    .tx_data_i      (tx_data_i),
    .bus_req_o      (bus_req_o),
    .bus_op_o       (bus_op),
    .bus_byte_o     (bus_byte_o),
    .bus_ack_o      (bus_ack_o),
    .tx_pop_o       (tx_pop_o),
    .rx_push_o      (rx_push_o),
    .rx_data_o      (rx_data_o),
    .load_o         (load),
    .start_evt_o    (start_evt),
    .ok_evt_o       (ok_evt),
    .abort_evt_o    (abort_evt),
    .cause_o        (cause),
    .cnt_o          (cnt),
    .done_o         (done_o),
    .done_nostop_o  (done_nostop_o)
  );

  i2c_xact_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .rd_i        (fld.rd),
    .start_evt_i (start_evt),
    .ok_evt_i    (ok_evt),
    .abort_evt_i (abort_evt),
    .cause_i     (cause),
    .cnt_i       (cnt),
    .status_o    (status_o)
  );

  assign bus_op_o = bus_op;
endmodule

// File: tb/sim_i2c_xact_ctrl.sv
module sim_i2c_xact_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  localparam int TB_MAX = 64;

  typedef struct packed {
    logic [31:0] cmd;
    logic [1:0]  kind;
    logic [3:0]  at;
    logic [1:0]  st;
    logic [2:0]  cause;
    logic [10:0] cnt;
    logic [4:0]  ops;
    logic        dn;
    logic        dns;
    logic [7:0]  a0;
  } vec_t;

  function automatic logic [31:0] mk(input logic rd, input logic [6:0] a7, input logic [2:0] ext,
                                     input logic sb, input logic [1:0] am, input logic stop,
                                     input logic [10:0] len);
    mk = {6'b0, len, stop, am, sb, ext, a7, rd};
  endfunction

  // kind: 0 none, 1 nack, 2 arbitration loss, 3 bus error; at = request index
  localparam vec_t VT [NV] = '{
    '{mk(0,7'h50,3'd0,0,2'd1,1,11'd3),   2'd0,4'd0,2'd2,3'd0,11'd3,5'd6,1'b1,1'b0,8'hA0}, // R1
    '{mk(1,7'h21,3'd0,0,2'd1,1,11'd2),   2'd0,4'd0,2'd2,3'd0,11'd2,5'd5,1'b1,1'b0,8'h43}, // R4
    '{mk(0,7'h15,3'd5,0,2'd2,1,11'd1),   2'd0,4'd0,2'd2,3'd0,11'd1,5'd5,1'b1,1'b0,8'hF4}, // R2
    '{mk(1,7'h15,3'd5,0,2'd2,1,11'd1),   2'd0,4'd0,2'd2,3'd0,11'd1,5'd7,1'b1,1'b0,8'hF4}, // R2
    '{mk(0,7'h50,3'd0,0,2'd1,1,11'd0),   2'd0,4'd0,2'd2,3'd0,11'd0,5'd3,1'b1,1'b0,8'hA0}, // R5
    '{mk(0,7'h50,3'd0,0,2'd1,1,11'd2),   2'd1,4'd1,2'd3,3'd0,11'd0,5'd2,1'b0,1'b0,8'hA0}, // R8
    '{mk(0,7'h50,3'd0,0,2'd1,1,11'd2),   2'd1,4'd3,2'd3,3'd1,11'd1,5'd4,1'b0,1'b0,8'hA0}, // R8
    '{mk(1,7'h21,3'd0,0,2'd1,1,11'd2),   2'd2,4'd1,2'd3,3'd3,11'd0,5'd2,1'b0,1'b0,8'h43}, // R9
    '{mk(1,7'h21,3'd0,0,2'd1,1,11'd2),   2'd3,4'd2,2'd3,3'd7,11'd0,5'd3,1'b0,1'b0,8'h43}, // R9
    '{mk(0,7'h50,3'd0,0,2'd1,1,11'd100), 2'd0,4'd0,2'd3,3'd6,11'd0,5'd0,1'b0,1'b0,8'h00}, // R10
    '{mk(0,7'h50,3'd0,1,2'd1,1,11'd0),   2'd0,4'd0,2'd2,3'd0,11'd0,5'd5,1'b1,1'b0,8'h01}, // R3
    '{mk(0,7'h50,3'd0,0,2'd1,0,11'd1),   2'd0,4'd0,2'd2,3'd0,11'd1,5'd3,1'b0,1'b1,8'hA0}, // R6
    '{mk(1,7'h50,3'd0,0,2'd1,1,11'd1),   2'd0,4'd0,2'd2,3'd0,11'd1,5'd4,1'b1,1'b0,8'hA1}  // R6
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_we;
  logic [31:0] cmd;
  logic bus_req, bus_ack, bd, bn, ba, be, tx_pop, rx_push, done_p, dns_p;
  logic [1:0] bus_op;
  logic [7:0] bus_byte, brd, rx_data;
  logic [31:0] status;
  logic [15:0] n_log, n_dn, n_dns, n_rx, tx_idx, inj_abs;
  logic [1:0] inj_kind;
  logic [1:0] log_op [256];
  logic [7:0] log_byte [256];
  logic       log_ack [256];
  logic [7:0] rx_log [256];
  int n_chk = 0;
  int n_fail = 0;
  string vtag [NV];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xact_ctrl #(.CMD_W(32), .MAX_LEN(TB_MAX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .bus_req_o(bus_req), .bus_op_o(bus_op), .bus_byte_o(bus_byte), .bus_ack_o(bus_ack),
    .bus_done_i(bd), .bus_nack_i(bn), .bus_arb_lost_i(ba), .bus_err_i(be), .bus_rdata_i(brd),
    .tx_valid_i(1'b1), .tx_data_i(8'hD0 + tx_idx[7:0]), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_data), .status_o(status),
    .done_o(done_p), .done_nostop_o(dns_p)
  );

  // bit engine model: answers each request one cycle after it appears
  always @(posedge clk) begin
    if (!rst_n) begin
      bd <= 1'b0; bn <= 1'b0; ba <= 1'b0; be <= 1'b0; brd <= 8'h00;
      n_log <= '0; n_dn <= '0; n_dns <= '0; n_rx <= '0; tx_idx <= '0;
    end else begin
      bd <= 1'b0; bn <= 1'b0; ba <= 1'b0; be <= 1'b0;
      if (bus_req && !bd) begin
        bd  <= 1'b1;
        bn  <= (inj_kind == 2'd1) && (n_log == inj_abs);
        ba  <= (inj_kind == 2'd2) && (n_log == inj_abs);
        be  <= (inj_kind == 2'd3) && (n_log == inj_abs);
        brd <= 8'hA0 + n_log[7:0];
      end
      if (bus_req && bd) begin
        log_op[n_log[7:0]]   <= bus_op;
        log_byte[n_log[7:0]] <= bus_byte;
        log_ack[n_log[7:0]]  <= bus_ack;
        n_log <= n_log + 16'd1;
      end
      if (done_p) n_dn <= n_dn + 16'd1;
      if (dns_p) n_dns <= n_dns + 16'd1;
      if (rx_push) begin
        rx_log[n_rx[7:0]] <= rx_data;
        n_rx <= n_rx + 16'd1;
      end
      if (tx_pop) tx_idx <= tx_idx + 16'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] c);
    @(negedge clk);
    cmd = c;
    cmd_we = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_end();
    for (int g = 0; g < 2000 && status[3:2] == 2'd1; g++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_vec(input int i);
    logic [15:0] b_log, b_dn, b_dns;
    vec_t v;
    v = VT[i];
    b_log = n_log; b_dn = n_dn; b_dns = n_dns;
    inj_kind = v.kind;
    inj_abs = n_log + 16'(v.at);
    issue(v.cmd);
    wait_end();
    chk({vtag[i], " R7 status"}, status,
        {12'b0, v.cnt, 2'b00, v.cause, v.st, 1'b0, v.cmd[0]});
    chk({vtag[i], " requests"}, 32'(n_log - b_log), 32'(v.ops));
    chk({vtag[i], " R5 done"}, 32'(n_dn - b_dn), 32'(v.dn));
    chk({vtag[i], " R6 done_nostop"}, 32'(n_dns - b_dns), 32'(v.dns));
    if (v.ops >= 5'd2) begin
      chk({vtag[i], " R1 first op START"}, 32'(log_op[b_log[7:0]]), 32'd0);
      chk({vtag[i], " address byte"}, 32'(log_byte[b_log[7:0] + 8'd1]), 32'(v.a0));
    end
    inj_kind = 2'd0;
  endtask

  initial begin
    vtag = '{"R1", "R4", "R2", "R2", "R5", "R8", "R8", "R9", "R9", "R10", "R3", "R6", "R6"};
    rst_n = 1'b0; cmd_we = 1'b0; cmd = '0; inj_kind = 2'd0; inj_abs = '0;
    repeat (3) @(negedge clk);
    // R12
    chk("R12 status", status, 32'h0);
    chk("R12 outputs", {28'b0, bus_req, tx_pop, rx_push, done_p | dns_p}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 idle after reset", {31'b0, bus_req}, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(i);

    begin : rx_case // R4 read data and final NACK
      logic [15:0] b_log, b_rx;
      b_log = n_log; b_rx = n_rx;
      issue(mk(1, 7'h21, 3'd0, 0, 2'd1, 1, 11'd3));
      wait_end();
      chk("R4 rx count", 32'(n_rx - b_rx), 32'd3);
      for (int k = 0; k < 3; k++) begin
        chk("R4 rx byte", 32'(rx_log[b_rx[7:0] + 8'(k)]), 32'(8'hA0 + b_log[7:0] + 8'(k + 2)));
        chk("R4 read ack", 32'(log_ack[b_log[7:0] + 8'(k + 2)]), (k == 2) ? 32'd0 : 32'd1);
      end
    end

    begin : tx_and_busy // R4 write data; R11 ignored command while busy
      logic [15:0] b_log, b_tx;
      b_log = n_log; b_tx = tx_idx;
      issue(mk(0, 7'h50, 3'd0, 0, 2'd1, 1, 11'd2));
      @(negedge clk);
      cmd = mk(1, 7'h11, 3'd0, 0, 2'd1, 1, 11'd1);
      cmd_we = 1'b1;
      @(negedge clk);
      cmd_we = 1'b0;
      wait_end();
      chk("R4 tx byte0", 32'(log_byte[b_log[7:0] + 8'd2]), 32'(8'hD0 + b_tx[7:0]));
      chk("R4 tx byte1", 32'(log_byte[b_log[7:0] + 8'd3]), 32'(8'hD1 + b_tx[7:0]));
      chk("R11 busy cmd ignored requests", 32'(n_log - b_log), 32'd5);
      chk("R11 busy cmd ignored status", status, {12'b0, 11'd2, 2'b00, 3'd0, 2'd2, 2'b00});
    end

    // R11 cause held while idle
    issue(mk(0, 7'h50, 3'd0, 0, 2'd1, 1, 11'd70));
    repeat (10) @(negedge clk);
    chk("R11 cause held", 32'(status[6:2]), {27'b0, 3'd6, 2'd3});

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule